// File: doc/BRIEF.md
# Wired-AND Microcode Bus Source Selector

This block forms the 16-bit processor bus value for one microinstruction. A 3-bit bus-source code picks one data source: R-register read data, memory data, mouse bits, the displacement field of the instruction register, or one of two task-specific inputs. Two codes drive fixed patterns instead of data. The bus behaves as a wired-AND, so when several sources are enabled in the same cycle their values are ANDed together rather than multiplexed.

A 256-word constant ROM, filled from a parameter, is addressed by the register-select field concatenated above the bus-source code. Either special-function code equal to 7 gates the constant onto the bus. Any bus-source code above 4 also gates it. For those high source codes the constant acts as a per-source mask on the selected data. A control-RAM read requested in one cycle ANDs the control-RAM data onto the bus in the following cycle only. The bus value is combinational from the current inputs; the pending control-RAM flag is the only state.

Top module: `bus_src_sel`

## Requirements
- R1: Bus-source code 0 (read R) with neither F1 nor F2 equal to 7 and no control-RAM read pending puts `r_data_i` on the bus.
- R2: Bus-source code 1 (load R) with neither F1 nor F2 equal to 7 drives the bus to 0 and raises `load_r_o`. `load_r_o` is low for every other combination, including code 1 when F1 or F2 equals 7.
- R3: Bus-source code 2 (none) with neither F1 nor F2 equal to 7 and nothing pending leaves the bus all ones.
- R4: Bus-source codes 3 and 4 put `task_a_i` and `task_b_i` respectively on the bus when no constant is gated and nothing is pending.
- R5: Bus-source code 5 selects `md_i`, which is then masked by the constant (R9).
- R6: Bus-source code 6 places `mouse_i` on bus[3:0] and ones on bus[15:4] before the constant mask.
- R7: Bus-source code 7 places `ir_i[7:0]` on bus[7:0]. Bus[15:8] is all ones when `ir_i[9:8]` is non-zero and `ir_i[7]` is 1, and zero otherwise. The constant mask is applied after this.
- R8: The constant word is gated when `f1_i` equals 7, when `f2_i` equals 7, or when the bus-source code is above 4. Its ROM address is {`rsel_i`, `bus_src_i`}, with `rsel_i` in bits [7:3].
- R9: For bus-source codes 5 to 7 the bus is the selected source ANDed with the constant word.
- R10: When F1 or F2 equals 7 and the bus-source code is 4 or less, the bus carries the constant word alone.
- R11: When `cram_rd_i` is high at a rising clock edge, the bus in the following cycle is additionally ANDed with `cram_data_i`. Otherwise no such term applies. Reset clears the pending request.
- R12: The bus output follows changes of its data inputs within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_src_i | input | 3 | Bus-source code |
| f1_i | input | 4 | Special function 1 code |
| f2_i | input | 4 | Special function 2 code |
| rsel_i | input | 5 | Register-select field, upper constant ROM address |
| r_data_i | input | 16 | R-register read data |
| md_i | input | 16 | Memory data |
| mouse_i | input | 4 | Mouse bits |
| ir_i | input | 16 | Instruction register |
| task_a_i | input | 16 | First task-specific source |
| task_b_i | input | 16 | Second task-specific source |
| cram_data_i | input | 16 | Control-RAM read data |
| cram_rd_i | input | 1 | Control-RAM read request, applied next cycle |
| bus_o | output | 16 | Wired-AND bus value |
| load_r_o | output | 1 | Load-R source selected |

## Verification
Directed patterns first run each source code with no constant gated. Distinct data values on every input make a wrong source selection visible. Constant-gated cases on low codes then separate "constant alone" from "constant AND source". The displacement source is tried with a zero and a non-zero X field, each with bit 7 set and clear, which separates the sign-extension rule from plain zero fill. A control-RAM request lasting one cycle shows that the AND term lands exactly one cycle later and is gone the cycle after. Long random runs against the behavioural model cover combinations of constant gating, masking and pending reads together.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
  localparam int DW        = 16;
  localparam int MOUSE_W   = 4;
  localparam int RSEL_W    = 5;
  localparam int BS_W      = 3;
  localparam int FN_W      = 4;
  localparam int DISP_W    = 8;
  localparam int ROM_AW    = RSEL_W + BS_W;
  localparam int ROM_DEPTH = 1 << ROM_AW;

  localparam logic [FN_W-1:0] FN_CONST   = FN_W'(7);
  localparam logic [BS_W-1:0] MASK_ABOVE = BS_W'(4);

  typedef enum logic [BS_W-1:0] {
    SRC_RREG   = 3'd0,
    SRC_LOADR  = 3'd1,
    SRC_NONE   = 3'd2,
    SRC_TASK_A = 3'd3,
    SRC_TASK_B = 3'd4,
    SRC_MEM    = 3'd5,
    SRC_MOUSE  = 3'd6,
    SRC_DISP   = 3'd7
  } bus_src_e;

  typedef logic [ROM_DEPTH-1:0][DW-1:0] crom_t;

  function automatic crom_t crom_fill(input logic [DW-1:0] seed);
    crom_t t;
    logic [ROM_AW-1:0] ad;
    for (int a = 0; a < ROM_DEPTH; a++) begin
      ad   = ROM_AW'(a);
      t[a] = DW'({~ad, ad}) ^ seed;
    end
    return t;
  endfunction
endpackage

// File: rtl/bsel_decode.sv
module bsel_decode
  import bsel_pkg::*;
(
  input  logic [BS_W-1:0] bus_src_i,
  input  logic [FN_W-1:0] f1_i,
  input  logic [FN_W-1:0] f2_i,
  output logic            const_only_o,
  output logic            mask_en_o,
  output logic            load_r_o
);
  logic const_en;

  assign mask_en_o    = bus_src_i > MASK_ABOVE;
  assign const_en     = (f1_i == FN_CONST) || (f2_i == FN_CONST) || mask_en_o;
  assign const_only_o = const_en && !mask_en_o;
  // constant access replaces the source decode, so load-R is suppressed
  assign load_r_o     = (bus_src_i == SRC_LOADR) && !const_en;
endmodule

// File: rtl/bsel_src.sv
module bsel_src
  import bsel_pkg::*;
(
  input  logic [BS_W-1:0]    bus_src_i,
  input  logic [DW-1:0]      r_data_i,
  input  logic [DW-1:0]      md_i,
  input  logic [MOUSE_W-1:0] mouse_i,
  input  logic [DW-1:0]      ir_i,
  input  logic [DW-1:0]      task_a_i,
  input  logic [DW-1:0]      task_b_i,
  output logic [DW-1:0]      src_o
);
  logic disp_neg;
  logic [DW-1:0] disp_val;

  // X field non-zero selects relative addressing, displacement is signed
  assign disp_neg = (ir_i[DISP_W+1:DISP_W] != 2'b00) && ir_i[DISP_W-1];
  assign disp_val = {{(DW-DISP_W){disp_neg}}, ir_i[DISP_W-1:0]};

  always_comb begin
    unique case (bus_src_e'(bus_src_i))
      SRC_RREG:   src_o = r_data_i;
      SRC_LOADR:  src_o = '0;
      SRC_NONE:   src_o = '1;
      SRC_TASK_A: src_o = task_a_i;
      SRC_TASK_B: src_o = task_b_i;
      SRC_MEM:    src_o = md_i;
      SRC_MOUSE:  src_o = {{(DW-MOUSE_W){1'b1}}, mouse_i};
      SRC_DISP:   src_o = disp_val;
      default:    src_o = '1;
    endcase
  end
endmodule

// File: rtl/bsel_crom.sv
module bsel_crom
  import bsel_pkg::*;
#(
  parameter crom_t CROM = crom_fill(16'h5A3C)
) (
  input  logic [ROM_AW-1:0] addr_i,
  output logic [DW-1:0]     word_o
);
  assign word_o = CROM[addr_i];
endmodule

// File: rtl/bsel_cram_hold.sv
module bsel_cram_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= 1'b0;
    else         pend_o <= req_i;
  end

  a_r11_pend_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> pend_o);
  a_r11_pend_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !pend_o);
endmodule

// File: rtl/bus_src_sel.sv
module bus_src_sel
  import bsel_pkg::*;
#(
  parameter crom_t CROM = crom_fill(16'h5A3C)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [BS_W-1:0]    bus_src_i,
  input  logic [FN_W-1:0]    f1_i,
  input  logic [FN_W-1:0]    f2_i,
  input  logic [RSEL_W-1:0]  rsel_i,
  input  logic [DW-1:0]      r_data_i,
  input  logic [DW-1:0]      md_i,
  input  logic [MOUSE_W-1:0] mouse_i,
  input  logic [DW-1:0]      ir_i,
  input  logic [DW-1:0]      task_a_i,
  input  logic [DW-1:0]      task_b_i,
  input  logic [DW-1:0]      cram_data_i,
  input  logic               cram_rd_i,
  output logic [DW-1:0]      bus_o,
  output logic               load_r_o
);
  logic          const_only, mask_en, cram_pend;
  logic [DW-1:0] src_val, const_word, bus_pre;

  bsel_decode u_dec (
    .bus_src_i   (bus_src_i),
    .f1_i        (f1_i),
    .f2_i        (f2_i),
    .const_only_o(const_only),
    .mask_en_o   (mask_en),
    .load_r_o    (load_r_o)
  );

  bsel_src u_src (
    .bus_src_i(bus_src_i),
    .r_data_i (r_data_i),
    .md_i     (md_i),
    .mouse_i  (mouse_i),
    .ir_i     (ir_i),
    .task_a_i (task_a_i),
    .task_b_i (task_b_i),
    .src_o    (src_val)
  );

  bsel_crom #(.CROM(CROM)) u_crom (
    .addr_i({rsel_i, bus_src_i}),
    .word_o(const_word)
  );

  bsel_cram_hold u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (cram_rd_i),
    .pend_o(cram_pend)
  );

  always_comb begin
    if (const_only)   bus_pre = const_word;
    else if (mask_en) bus_pre = src_val & const_word;
    else              bus_pre = src_val;
  end

  assign bus_o = cram_pend ? (bus_pre & cram_data_i) : bus_pre;

  a_r3_none_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_src_i == SRC_NONE && f1_i != FN_CONST && f2_i != FN_CONST && !cram_pend)
      |-> bus_o == '1);
  a_r2_loadr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_r_o |-> (bus_o == '0 && bus_src_i == SRC_LOADR));
  a_r6_mouse_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_src_i == SRC_MOUSE && !cram_pend)
      |-> bus_o[DW-1:MOUSE_W] == const_word[DW-1:MOUSE_W]);
  a_r9_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_src_i > MASK_ABOVE) |-> (bus_o & ~const_word) == '0);
  a_r11_cram_and: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cram_pend |-> (bus_o & ~cram_data_i) == '0);
endmodule

// File: tb/tb_bus_src_sel.sv
`timescale 1ns/1ps
module tb_bus_src_sel;
  typedef logic [255:0][15:0] rom_t;

  function automatic rom_t tb_rom();
    rom_t t;
    for (int a = 0; a < 256; a++) begin
      if (a % 5 == 0) t[a] = 16'hFFFF;
      else            t[a] = 16'((a * 40503) ^ 16'h3C5A);
    end
    return t;
  endfunction

  localparam rom_t TB_ROM = tb_rom();

  logic        clk = 0, rst_n = 0;
  logic [2:0]  bs = 3'd2;
  logic [3:0]  f1 = 0, f2 = 0;
  logic [4:0]  rsel = 0;
  logic [15:0] r_data = 0, md = 0, ir = 0, ta = 0, tb = 0, cram = 0;
  logic [3:0]  mouse = 0;
  logic        cram_rd = 0;
  logic [15:0] bus;
  logic        load_r;

  int checks = 0, errors = 0;
  bit model_pend = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bus_src_sel #(.CROM(TB_ROM)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_src_i(bs), .f1_i(f1), .f2_i(f2),
    .rsel_i(rsel), .r_data_i(r_data), .md_i(md), .mouse_i(mouse), .ir_i(ir),
    .task_a_i(ta), .task_b_i(tb), .cram_data_i(cram), .cram_rd_i(cram_rd),
    .bus_o(bus), .load_r_o(load_r)
  );

  function automatic logic [15:0] ref_bus();
    logic [15:0] v, c;
    bit con;
    con = (f1 == 7) || (f2 == 7) || (bs > 4);
    c = TB_ROM[{rsel, bs}];
    case (bs)
      3'd0: v = r_data;
      3'd1: v = 16'h0000;
      3'd2: v = 16'hFFFF;
      3'd3: v = ta;
      3'd4: v = tb;
      3'd5: v = md;
      3'd6: v = {12'hFFF, mouse};
      default: v = {((ir[9:8] != 0) && ir[7]) ? 8'hFF : 8'h00, ir[7:0]};
    endcase
    if (con && bs <= 4) v = c;
    if (bs > 4) v &= c;
    if (model_pend) v &= cram;
    return v;
  endfunction

  function automatic bit ref_load();
    return (bs == 1) && (f1 != 7) && (f2 != 7);
  endfunction

  task automatic compare(input string tag);
    logic [15:0] e;
    e = ref_bus();
    checks++;
    if (bus !== e) begin
      errors++;
      $display("FAIL %s bus act=%h exp=%h", tag, bus, e);
    end
    checks++;
    if (load_r !== ref_load()) begin
      errors++;
      $display("FAIL %s load_r act=%b exp=%b", tag, load_r, ref_load());
    end
  endtask

  // inputs already driven after a falling edge; check, then cross one rising edge
  task automatic cyc(input string tag);
    #1 compare(tag);
    @(posedge clk);
    model_pend = cram_rd;
    @(negedge clk);
  endtask

  task automatic ops(input logic [2:0] b, input logic [3:0] a1, input logic [3:0] a2,
                     input logic [4:0] rs);
    bs = b; f1 = a1; f2 = a2; rsel = rs;
  endtask

  initial begin
    r_data = 16'h1234; md = 16'hBEEF; ta = 16'hA5A5; tb = 16'h0F0F;
    cram = 16'hF0F3; mouse = 4'hA; ir = 16'h0080;
    cram_rd = 1;
    repeat (3) @(negedge clk);
    compare("R11 reset state");
    cram_rd = 0;
    rst_n = 1;
    @(posedge clk); model_pend = cram_rd; @(negedge clk);

    ops(0, 0, 0, 5'd9);  cyc("R1 read R");
    r_data = 16'h8001;   cyc("R1 read R second value");
    ops(1, 0, 0, 5'd2);  cyc("R2 load R zero");
    ops(1, 7, 0, 5'd2);  cyc("R2 R10 load R under constant");
    ops(2, 0, 0, 5'd4);  cyc("R3 none ones");
    ops(3, 0, 0, 5'd1);  cyc("R4 task A");
    ops(4, 0, 0, 5'd1);  cyc("R4 task B");
    ops(5, 0, 0, 5'd0);  cyc("R5 memory unmasked const");
    ops(5, 0, 0, 5'd6);  cyc("R5 R9 memory masked");
    ops(6, 0, 0, 5'd3);  cyc("R6 mouse");
    mouse = 4'h5;        cyc("R6 mouse second pattern");
    ops(6, 0, 0, 5'd7);  cyc("R6 R9 mouse masked");
    ops(7, 0, 0, 5'd1); ir = 16'h0080; cyc("R7 disp X zero bit7 set");
    ir = 16'h0180;       cyc("R7 disp X one sign extend");
    ir = 16'h027F;       cyc("R7 disp X two bit7 clear");
    ir = 16'h03C4;       cyc("R7 disp X three negative");
    ops(7, 0, 0, 5'd12); ir = 16'h0281; cyc("R7 R9 disp masked");
    ops(0, 0, 7, 5'd13); cyc("R8 R10 F2 constant alone");
    ops(3, 7, 0, 5'd31); cyc("R8 R10 F1 constant alone");
    ops(2, 7, 7, 5'd21); cyc("R8 R10 both constant");
    ops(4, 6, 8, 5'd21); cyc("R8 near codes no constant");
    ops(2, 0, 0, 5'd0); cram_rd = 1; cyc("R11 request cycle");
    cram_rd = 0;         cyc("R11 data ANDed next cycle");
    cyc("R11 cleared after one cycle");
    ops(0, 0, 0, 5'd0); r_data = 16'h00FF; #1 compare("R12 comb first");
    r_data = 16'hFF00;   #1 compare("R12 comb second");
    @(negedge clk);

    for (int i = 0; i < 2000; i++) begin
      bs = 3'($urandom); rsel = 5'($urandom);
      f1 = ($urandom % 4 == 0) ? 4'd7 : 4'($urandom);
      f2 = ($urandom % 4 == 0) ? 4'd7 : 4'($urandom);
      r_data = 16'($urandom); md = 16'($urandom); ir = 16'($urandom);
      ta = 16'($urandom); tb = 16'($urandom); cram = 16'($urandom);
      mouse = 4'($urandom); cram_rd = ($urandom % 3 == 0);
      cyc("R9 random mix");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule